// File: doc/BRIEF.md
# GPIO Edge Interrupt and Wakeup Unit

This block watches a bank of already-synchronized GPIO inputs and turns pin transitions into interrupt and wakeup events. Each pin has four enables: one for rising edges and one for falling edges that feed a sticky interrupt status vector, and a second rising/falling pair that feeds a separate sticky wakeup status vector. A pin may have both edges enabled in either pair. The two pairs are independent, so software can narrow the wakeup enables before sleep and put them back afterwards without touching the interrupt enables.

The interrupt output stays high while any interrupt status bit is set. Software reads the status vector, services pins from the lowest set bit upward, and acknowledges them by writing ones to the clear offset. The wakeup output works the same way from the wakeup status vector, which is acknowledged by writing ones to its own offset. An edge that arrives in the same cycle as its acknowledge is kept. The registers sit on a simple 32-bit word bus shared with the rest of the GPIO bank. Reads are combinational and writes take effect at the clock edge.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset all enables and both status vectors read 0 and `irq_o` and `wake_o` are low. Pin levels present when reset is released produce no event.
- R2: A 0-to-1 change on pin n sets bit n of the interrupt status (offset 0x48) only when bit n of the rising interrupt enable (offset 0x40) is 1.
- R3: A 1-to-0 change on pin n sets bit n of the interrupt status only when bit n of the falling interrupt enable (offset 0x44) is 1.
- R4: With both interrupt enable bits of a pin set, both the rising and the falling transition of that pin set its status bit.
- R5: Writing to offset 0x4C clears each interrupt status bit whose data bit is 1 and leaves the bits written as 0 unchanged. Offset 0x4C reads as 0.
- R6: If a pin event and an acknowledge of the same bit fall in the same cycle, the status bit ends up set.
- R7: `irq_o` is high exactly while the interrupt status is nonzero, and it can only rise after a cycle with an enabled interrupt event.
- R8: Wakeup status (offset 0x58) bits are set only through the rising wakeup enable (offset 0x50) and the falling wakeup enable (offset 0x54). The interrupt enables never set wakeup status, and the wakeup enables never set interrupt status.
- R9: Writing ones to offset 0x58 clears those wakeup status bits, bits written as 0 are kept, and `wake_o` is high exactly while the wakeup status is nonzero.
- R10: Writes to the wakeup enables leave the interrupt enables unchanged.
- R11: The four enable registers read back the value last written, and offsets outside the seven mapped ones read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Synchronized pin levels |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | NUM_PINS | Write data |
| bus_rdata_o | output | NUM_PINS | Read data for bus_addr_i |
| irq_o | output | 1 | Any interrupt status bit set |
| wake_o | output | 1 | Any wakeup status bit set |

## Verification
The bench builds the block at its default width of 32 pins and an 8-bit offset. This is small enough to visit every pin under every combination of rising and falling enables. In each combination the wakeup enables are crossed against the interrupt enables, so a leak from one path into the other shows up at once. Whole-word acknowledges with mixed ones and zeros, an event that coincides with its acknowledge, and readback of the enables after wakeup narrowing are checked on top of that sweep.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam logic [7:0] OFF_RISE_IRQ  = 8'h40;
  localparam logic [7:0] OFF_FALL_IRQ  = 8'h44;
  localparam logic [7:0] OFF_IRQ_STAT  = 8'h48;
  localparam logic [7:0] OFF_IRQ_CLR   = 8'h4C;
  localparam logic [7:0] OFF_RISE_WAKE = 8'h50;
  localparam logic [7:0] OFF_FALL_WAKE = 8'h54;
  localparam logic [7:0] OFF_WAKE_STAT = 8'h58;

  localparam int NUM_MASKS = 4;

  // enable register index -> offset
  function automatic logic [7:0] mask_offset(int idx);
    case (idx)
      0:       return OFF_RISE_IRQ;
      1:       return OFF_FALL_IRQ;
      2:       return OFF_RISE_WAKE;
      default: return OFF_FALL_WAKE;
    endcase
  endfunction
endpackage

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;

  // first cycle after reset only captures the pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pins_i;
      primed_q <= 1'b1;
    end
  end

  assign rise_o = primed_q ? (pins_i & ~prev_q) : '0;
  assign fall_o = primed_q ? (~pins_i & prev_q) : '0;

  p_edges_after_prime_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> ((rise_o | fall_o) == '0));
endmodule

// File: rtl/gei_sticky.sv
module gei_sticky #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] stat_o
);
  logic [NUM_PINS-1:0] stat_q;

  // set beats clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  p_clear_takes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  p_no_spontaneous_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/gei_regs.sv
module gei_regs
  import gei_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  input  logic [NUM_PINS-1:0] irq_stat_i,
  input  logic [NUM_PINS-1:0] wake_stat_i,
  output logic [NUM_PINS-1:0] rise_irq_en_o,
  output logic [NUM_PINS-1:0] fall_irq_en_o,
  output logic [NUM_PINS-1:0] rise_wake_en_o,
  output logic [NUM_PINS-1:0] fall_wake_en_o,
  output logic [NUM_PINS-1:0] irq_clr_o,
  output logic [NUM_PINS-1:0] wake_clr_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic [NUM_PINS-1:0] mask_q [NUM_MASKS];
  logic [NUM_MASKS-1:0] mask_hit;

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    assign mask_hit[g] = (bus_addr_i == ADDR_W'(mask_offset(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     mask_q[g] <= '0;
      else if (bus_we_i && mask_hit[g]) mask_q[g] <= bus_wdata_i;
    end
  end

  assign rise_irq_en_o  = mask_q[0];
  assign fall_irq_en_o  = mask_q[1];
  assign rise_wake_en_o = mask_q[2];
  assign fall_wake_en_o = mask_q[3];

  assign irq_clr_o  = (bus_we_i && bus_addr_i == ADDR_W'(OFF_IRQ_CLR))   ? bus_wdata_i : '0;
  assign wake_clr_o = (bus_we_i && bus_addr_i == ADDR_W'(OFF_WAKE_STAT)) ? bus_wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_MASKS; i++)
      if (mask_hit[i]) rdata_o = mask_q[i];
    if (bus_addr_i == ADDR_W'(OFF_IRQ_STAT))  rdata_o = irq_stat_i;
    if (bus_addr_i == ADDR_W'(OFF_WAKE_STAT)) rdata_o = wake_stat_i;
  end

  p_mask_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_hit));
endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
  import gei_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] rise, fall;
  logic [NUM_PINS-1:0] rise_irq_en, fall_irq_en, rise_wake_en, fall_wake_en;
  logic [NUM_PINS-1:0] irq_clr, wake_clr, irq_set, wake_set;
  logic [NUM_PINS-1:0] irq_stat, wake_stat;

  gei_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i, .rst_ni, .pins_i, .rise_o(rise), .fall_o(fall)
  );

  gei_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i,
    .irq_stat_i(irq_stat), .wake_stat_i(wake_stat),
    .rise_irq_en_o(rise_irq_en), .fall_irq_en_o(fall_irq_en),
    .rise_wake_en_o(rise_wake_en), .fall_wake_en_o(fall_wake_en),
    .irq_clr_o(irq_clr), .wake_clr_o(wake_clr), .rdata_o(bus_rdata_o)
  );

  assign irq_set  = (rise & rise_irq_en)  | (fall & fall_irq_en);
  assign wake_set = (rise & rise_wake_en) | (fall & fall_wake_en);

  gei_sticky #(.NUM_PINS(NUM_PINS)) u_irq_stat (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(irq_clr), .stat_o(irq_stat)
  );

  gei_sticky #(.NUM_PINS(NUM_PINS)) u_wake_stat (
    .clk_i, .rst_ni, .set_i(wake_set), .clr_i(wake_clr), .stat_o(wake_stat)
  );

  assign irq_o  = |irq_stat;
  assign wake_o = |wake_stat;

  p_irq_needs_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_set != '0));

  p_wake_rise_needs_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(wake_set != '0));

  p_wake_write_keeps_irq_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && (bus_addr_i == ADDR_W'(OFF_RISE_WAKE) || bus_addr_i == ADDR_W'(OFF_FALL_WAKE)))
    |=> ($stable(rise_irq_en) && $stable(fall_irq_en)));
endmodule

// File: tb/gpio_edge_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit_tb_top;
  localparam int NP = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic          irq, wake;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_edge_irq_unit #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [NP-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic drive_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NP-1:0] v;
    logic [NP-1:0] bit_m;
    // R1: pins nonzero across reset release
    pins = 32'hA5A5_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 irq_o", {31'd0, irq}, '0);
    chk("R1 wake_o", {31'd0, wake}, '0);
    rd(8'h40, v); chk("R1 rise irq en", v, '0);
    rd(8'h54, v); chk("R1 fall wake en", v, '0);
    rd(8'h48, v); chk("R1 irq stat", v, '0);
    rd(8'h58, v); chk("R1 wake stat", v, '0);

    // R11 readback and unmapped offsets
    wr(8'h40, 32'h1234_5678); rd(8'h40, v); chk("R11 0x40", v, 32'h1234_5678);
    wr(8'h44, 32'h8765_4321); rd(8'h44, v); chk("R11 0x44", v, 32'h8765_4321);
    wr(8'h50, 32'hDEAD_BEEF); rd(8'h50, v); chk("R11 0x50", v, 32'hDEAD_BEEF);
    wr(8'h54, 32'h0F0F_F0F0); rd(8'h54, v); chk("R11 0x54", v, 32'h0F0F_F0F0);
    rd(8'h5C, v); chk("R11 unmapped 0x5C", v, '0);
    rd(8'h00, v); chk("R11 unmapped 0x00", v, '0);
    rd(8'h4C, v); chk("R5 clear reads zero", v, '0);

    // R10: narrowing wakeup enables leaves interrupt enables alone
    wr(8'h50, 32'h0000_0001);
    wr(8'h54, 32'h0000_0000);
    rd(8'h40, v); chk("R10 rise irq en kept", v, 32'h1234_5678);
    rd(8'h44, v); chk("R10 fall irq en kept", v, 32'h8765_4321);
    rd(8'h50, v); chk("R10 wake narrowed", v, 32'h0000_0001);

    // quiet state
    wr(8'h40, '0); wr(8'h44, '0); wr(8'h50, '0); wr(8'h54, '0);
    drive_pins('0);
    wr(8'h4C, '1); wr(8'h58, '1);
    rd(8'h48, v); chk("R1 no event from reset levels", v, '0);

    // sweep: every pin, every enable combination; wake enables crossed
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        bit_m = NP'(1) << p;
        wr(8'h40, m[0] ? bit_m : '0);
        wr(8'h44, m[1] ? bit_m : '0);
        wr(8'h50, m[1] ? bit_m : '0);
        wr(8'h54, m[0] ? bit_m : '0);
        drive_pins(bit_m);
        rd(8'h48, v); chk("R2 rising sets irq stat", v, m[0] ? bit_m : '0);
        chk("R7 irq_o after rise", {31'd0, irq}, {31'd0, m[0]});
        rd(8'h58, v); chk("R8 rising wake stat", v, m[1] ? bit_m : '0);
        chk("R9 wake_o after rise", {31'd0, wake}, {31'd0, m[1]});
        wr(8'h4C, '1); wr(8'h58, '1);
        rd(8'h48, v); chk("R5 irq stat cleared", v, '0);
        rd(8'h58, v); chk("R9 wake stat cleared", v, '0);
        drive_pins('0);
        rd(8'h48, v); chk(m == 3 ? "R4 both edges falling" : "R3 falling sets irq stat",
                          v, m[1] ? bit_m : '0);
        rd(8'h58, v); chk("R8 falling wake stat", v, m[0] ? bit_m : '0);
        chk("R7 irq_o after fall", {31'd0, irq}, {31'd0, m[1]});
        wr(8'h4C, '1); wr(8'h58, '1);
        chk("R7 irq_o low after clear", {31'd0, irq}, '0);
      end
    end

    // R5: bits written as zero are kept
    wr(8'h40, '1); wr(8'h44, '0); wr(8'h50, '1); wr(8'h54, '0);
    drive_pins('1);
    wr(8'h4C, 32'h0000_FFFF);
    rd(8'h48, v); chk("R5 partial clear", v, 32'hFFFF_0000);
    chk("R7 irq_o still high", {31'd0, irq}, 32'd1);
    wr(8'h58, 32'hF0F0_F0F0);
    rd(8'h58, v); chk("R9 partial wake clear", v, 32'h0F0F_0F0F);
    wr(8'h4C, '1);
    rd(8'h48, v); chk("R5 full clear", v, '0);

    // R6: event and acknowledge of the same bit in one cycle
    wr(8'h44, 32'h0000_0008);
    @(negedge clk);
    pins = 32'hFFFF_FFF7;
    addr = 8'h4C; wdata = 32'h0000_0008; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(8'h48, v); chk("R6 set wins over clear", v, 32'h0000_0008);
    chk("R7 irq_o with set-wins bit", {31'd0, irq}, 32'd1);

    finish_run();
  end
endmodule